// File: doc/BRIEF.md
# Debug Control and Instruction Break Unit

This block is the memory-mapped debug register set that sits next to a small 16-bit CPU core with a 24-bit address space. The core reaches it through a simple single-cycle register port. A byte-wide control register holds two break-enable bits and a single-step enable bit. It also reports a sticky external-request flag and the core's current debug/user mode. Two 24-bit break address registers and a read-only work-area base register complete the set.

On every fetch strobe the block compares the fetch address with each enabled break address. In the same cycle it raises a one-cycle break pulse for every comparator that matches. Comparison is suppressed while the core reports debug mode, so the handler cannot re-trigger itself. An external debug request is captured by a two-state machine. In `REQ_IDLE` a request moves it to `REQ_PENDING` (transition "latch"). In `REQ_PENDING` a write of 1 to the flag bit returns it to `REQ_IDLE` (transition "acknowledge"), unless a new request arrives in the same cycle, which keeps it pending. The work-area base is a build-time parameter, forced to 64-byte alignment.

Top module: `dbg_break_unit`

## Requirements
- R1: After reset the control register at 0xFFFFA0 reads 0 (with the mode input low), both break address registers read 0, `step_en` is 0 and `brk_pulse` is 0.
- R2: Control bits 3, 2 and 1 are read/write; bits 7 to 5 and bits 31 to 8 of a control read are always 0 regardless of what was written.
- R3: An external request (`ext_dbg_req` high at a clock edge) sets the flag in control bit 4 from the next cycle on, and it stays set without further requests.
- R4: Writing the control register with data bit 4 = 1 clears the flag; writing with bit 4 = 0 leaves it unchanged.
- R5: When a request and a clearing write fall in the same cycle, the flag stays 1.
- R6: Control bit 0 reads the level of `core_dbg_mode`; writes to bit 0 have no effect.
- R7: With its enable bit set (bit 2 for break 0, bit 3 for break 1), break n drives `brk_pulse[n]` high in exactly the cycle where `fetch_valid` is high and `fetch_addr` equals break address register n; both bits may fire together.
- R8: With its enable bit clear, a break never pulses, even on a matching fetch.
- R9: While `core_dbg_mode` is 1, `brk_pulse` stays 0.
- R10: The base register at 0xFFFF90 reads the build-time base with bits 31 to 24 and bits 5 to 0 at 0; writes to it are ignored.
- R11: Break address registers 0 and 1 at 0xFFFFB0 and 0xFFFFB4 store write-data bits 23 to 0 and read back with bits 31 to 24 at 0.
- R12: `step_en` equals control bit 1 and changes only on a control write.
- R13: Reads of unmapped addresses return 0, writes to them change no register, and `reg_rdata` is 0 whenever `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 24 | Register access address |
| reg_wr | input | 1 | Write strobe, applied at the clock edge |
| reg_rd | input | 1 | Read strobe, data returned in the same cycle |
| reg_wdata | input | 24 | Write data |
| reg_rdata | output | 32 | Read data, 0 when not reading |
| ext_dbg_req | input | 1 | External debug request |
| core_dbg_mode | input | 1 | Core is in debug mode |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 24 | Instruction fetch address |
| brk_pulse | output | 2 | Per-comparator break request |
| step_en | output | 1 | Single-step enable to the core |

## Verification
The bound checker watches on every cycle how the request flag moves between its two states: latch on a request, hold without one, acknowledge on a clearing write, and no acknowledge against a concurrent request. It also checks that break pulses only occur on a fetch strobe and never in debug mode, that read data is idle when no read is issued, and that `step_en` only moves on a write. The address comparison itself, the enable gating per comparator, the read-only nature of the mode and base fields, the masking of reserved bits and the harmlessness of unmapped writes depend on specific data values. Only the bench's scenarios, read back through the register port and observed on the break outputs, can show those.

// File: rtl/dbg_unit_pkg.sv
package dbg_unit_pkg;

    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 32;
    localparam int BRK_CNT = 2;

    localparam logic [ADDR_W-1:0] A_RAMBASE  = 24'hFFFF90;
    localparam logic [ADDR_W-1:0] A_CTRL     = 24'hFFFFA0;
    localparam logic [ADDR_W-1:0] A_BRK_BASE = 24'hFFFFB0;
    localparam int                A_BRK_STEP = 4;

    localparam int CB_MODE = 0;
    localparam int CB_STEP = 1;
    localparam int CB_EN0  = 2;
    localparam int CB_REQ  = CB_EN0 + BRK_CNT;

    localparam int BASE_ALIGN_BITS = 6;

    typedef enum logic [0:0] {
        REQ_IDLE    = 1'b0,
        REQ_PENDING = 1'b1
    } req_state_e;

endpackage

// File: rtl/dbg_req_fsm.sv
module dbg_req_fsm
    import dbg_unit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic clr_in,
    output logic flag_o
);

    req_state_e state_q;
    req_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: begin
                if (req_in) begin
                    state_d = REQ_PENDING;
                end
            end
            REQ_PENDING: begin
                if (clr_in && !req_in) begin
                    state_d = REQ_IDLE;
                end
            end
            default: state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            REQ_IDLE:    flag_o = 1'b0;
            REQ_PENDING: flag_o = 1'b1;
            default:     flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbg_ctrl_regs.sv
module dbg_ctrl_regs
    import dbg_unit_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_BASE = 24'h001000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic                            reg_wr,
    input  logic                            reg_rd,
    input  logic [ADDR_W-1:0]               reg_wdata,
    input  logic                            req_flag,
    input  logic                            dbg_mode,
    output logic [DATA_W-1:0]               reg_rdata,
    output logic                            step_en,
    output logic                            req_clr,
    output logic [BRK_CNT-1:0]              brk_en,
    output logic [BRK_CNT-1:0][ADDR_W-1:0]  brk_addr
);

    localparam logic [ADDR_W-1:0] BASE_MASK = ~ADDR_W'((1 << BASE_ALIGN_BITS) - 1);
    localparam logic [ADDR_W-1:0] BASE_AL   = RAM_BASE & BASE_MASK;

    logic               sel_ctrl;
    logic               sel_base;
    logic [BRK_CNT-1:0] sel_brk;
    logic               step_q;
    logic [BRK_CNT-1:0] en_q;
    logic [DATA_W-1:0]  rd_val;

    assign sel_ctrl = (reg_addr == A_CTRL);
    assign sel_base = (reg_addr == A_RAMBASE);

    genvar gi;
    generate
        for (gi = 0; gi < BRK_CNT; gi++) begin : g_slot
            localparam logic [ADDR_W-1:0] SLOT = A_BRK_BASE + ADDR_W'(gi * A_BRK_STEP);
            logic [ADDR_W-1:0] addr_q;

            assign sel_brk[gi] = (reg_addr == SLOT);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    addr_q <= '0;
                end else if (reg_wr && sel_brk[gi]) begin
                    addr_q <= reg_wdata;
                end
            end

            assign brk_addr[gi] = addr_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= 1'b0;
            en_q   <= '0;
        end else if (reg_wr && sel_ctrl) begin
            step_q <= reg_wdata[CB_STEP];
            en_q   <= reg_wdata[CB_EN0 +: BRK_CNT];
        end
    end

    assign req_clr = reg_wr && sel_ctrl && reg_wdata[CB_REQ];
    assign step_en = step_q;
    assign brk_en  = en_q;

    always_comb begin
        rd_val = '0;
        if (sel_ctrl) begin
            rd_val[CB_MODE]           = dbg_mode;
            rd_val[CB_STEP]           = step_q;
            rd_val[CB_EN0 +: BRK_CNT] = en_q;
            rd_val[CB_REQ]            = req_flag;
        end
        if (sel_base) begin
            rd_val[ADDR_W-1:0] = BASE_AL;
        end
        for (int k = 0; k < BRK_CNT; k++) begin
            if (sel_brk[k]) begin
                rd_val[ADDR_W-1:0] = brk_addr[k];
            end
        end
    end

    assign reg_rdata = reg_rd ? rd_val : '0;

endmodule

// File: rtl/dbg_brk_cmp.sv
module dbg_brk_cmp
    import dbg_unit_pkg::*;
(
    input  logic                           fetch_valid,
    input  logic [ADDR_W-1:0]              fetch_addr,
    input  logic                           dbg_mode,
    input  logic [BRK_CNT-1:0]             brk_en,
    input  logic [BRK_CNT-1:0][ADDR_W-1:0] brk_addr,
    output logic [BRK_CNT-1:0]             hit
);

    logic armed;
    assign armed = fetch_valid && !dbg_mode;

    genvar gi;
    generate
        for (gi = 0; gi < BRK_CNT; gi++) begin : g_cmp
            assign hit[gi] = armed && brk_en[gi] && (fetch_addr == brk_addr[gi]);
        end
    endgenerate

endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit
    import dbg_unit_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DBG_RAM_BASE = 24'h001000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                ext_dbg_req,
    input  logic                core_dbg_mode,
    input  logic                fetch_valid,
    input  logic [ADDR_W-1:0]   fetch_addr,
    output logic [BRK_CNT-1:0]  brk_pulse,
    output logic                step_en
);

    logic                           req_flag;
    logic                           req_clr;
    logic [BRK_CNT-1:0]             brk_en;
    logic [BRK_CNT-1:0][ADDR_W-1:0] brk_addr;

    dbg_req_fsm u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (ext_dbg_req),
        .clr_in (req_clr),
        .flag_o (req_flag)
    );

    dbg_ctrl_regs #(
        .RAM_BASE (DBG_RAM_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .req_flag  (req_flag),
        .dbg_mode  (core_dbg_mode),
        .reg_rdata (reg_rdata),
        .step_en   (step_en),
        .req_clr   (req_clr),
        .brk_en    (brk_en),
        .brk_addr  (brk_addr)
    );

    dbg_brk_cmp u_cmp (
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .dbg_mode    (core_dbg_mode),
        .brk_en      (brk_en),
        .brk_addr    (brk_addr),
        .hit         (brk_pulse)
    );

endmodule

// File: rtl/dbg_break_unit_chk.sv
module dbg_break_unit_chk
    import dbg_unit_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic               clr_bit,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               ext_dbg_req,
    input logic               core_dbg_mode,
    input logic               fetch_valid,
    input logic [BRK_CNT-1:0] brk_pulse,
    input logic               step_en,
    input logic               req_flag
);

    logic wr_clr;
    assign wr_clr = reg_wr && (reg_addr == A_CTRL) && clr_bit;

    p_req_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dbg_req |=> req_flag);

    p_req_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_flag && !ext_dbg_req) |=> !req_flag);

    p_req_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_flag && wr_clr && !ext_dbg_req) |=> !req_flag);

    p_req_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_flag && !wr_clr) |=> req_flag);

    p_brk_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pulse != '0) |-> fetch_valid);

    p_brk_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_dbg_mode |-> (brk_pulse == '0));

    p_rd_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));

    p_step_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(step_en));

endmodule

bind dbg_break_unit dbg_break_unit_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .clr_bit       (reg_wdata[dbg_unit_pkg::CB_REQ]),
    .reg_rdata     (reg_rdata),
    .ext_dbg_req   (ext_dbg_req),
    .core_dbg_mode (core_dbg_mode),
    .fetch_valid   (fetch_valid),
    .brk_pulse     (brk_pulse),
    .step_en       (step_en),
    .req_flag      (req_flag)
);

// File: tb/dbg_break_unit_bench.sv
`timescale 1ns/1ps
module dbg_break_unit_bench;

    localparam logic [23:0] BASE_P = 24'h3A51C0;

    localparam logic [23:0] AD_BASE = 24'hFFFF90;
    localparam logic [23:0] AD_CTRL = 24'hFFFFA0;
    localparam logic [23:0] AD_B0   = 24'hFFFFB0;
    localparam logic [23:0] AD_B1   = 24'hFFFFB4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [23:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_dbg_req = 1'b0;
    logic        core_dbg_mode = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [23:0] fetch_addr = '0;
    logic [1:0]  brk_pulse;
    logic        step_en;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    dbg_break_unit #(.DBG_RAM_BASE(BASE_P)) u_dbg_break_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ext_dbg_req   (ext_dbg_req),
        .core_dbg_mode (core_dbg_mode),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .brk_pulse     (brk_pulse),
        .step_en       (step_en)
    );

    // Monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (rst_n && reg_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL [unexpected read] actual=%h expected=none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    errors++;
                    $display("FAIL [%s] actual=%h expected=%h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL [%s] actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [23:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [23:0] a, input logic [31:0] exp, input string t);
        exp_q.push_back(exp);
        tag_q.push_back(t);
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic fetch(input logic [23:0] a, input logic v, input logic [1:0] exp, input string t);
        fetch_addr = a; fetch_valid = v;
        @(negedge clk);
        check({30'b0, brk_pulse}, {30'b0, exp}, t);
        @(posedge clk); #1;
        fetch_valid = 1'b0;
    endtask

    task automatic pulse_req();
        ext_dbg_req = 1'b1;
        @(posedge clk); #1;
        ext_dbg_req = 1'b0;
    endtask

    initial begin
        #(100000 * 8);
        errors++;
        $display("FAIL [watchdog] actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_read(AD_CTRL, 32'h0, "R1 ctrl");
        bus_read(AD_B0, 32'h0, "R1 brk0");
        bus_read(AD_B1, 32'h0, "R1 brk1");
        @(negedge clk);
        check({31'b0, step_en}, 32'h0, "R1 step_en");
        check({30'b0, brk_pulse}, 32'h0, "R1 brk_pulse");
        @(posedge clk); #1;

        // R10 base register, aligned, read-only
        bus_read(AD_BASE, 32'h003A51C0, "R10 base");
        bus_write(AD_BASE, 24'h000000);
        bus_read(AD_BASE, 32'h003A51C0, "R10 base after write");

        // R2 control bits, reserved bits, R12 step output
        bus_write(AD_CTRL, 24'hFFFFEE);
        bus_read(AD_CTRL, 32'h0000000E, "R2 ctrl rw");
        @(negedge clk);
        check({31'b0, step_en}, 32'h1, "R12 step on");
        @(posedge clk); #1;
        bus_write(AD_CTRL, 24'h000000);
        bus_read(AD_CTRL, 32'h0, "R2 ctrl cleared");
        @(negedge clk);
        check({31'b0, step_en}, 32'h0, "R12 step off");
        @(posedge clk); #1;

        // R11 break address registers
        bus_write(AD_B0, 24'h123456);
        bus_write(AD_B1, 24'hABCDE0);
        bus_read(AD_B0, 32'h00123456, "R11 brk0");
        bus_read(AD_B1, 32'h00ABCDE0, "R11 brk1");

        // R7 comparators
        bus_write(AD_CTRL, 24'h00000C);
        fetch(24'h123456, 1'b1, 2'b01, "R7 hit0");
        fetch(24'hABCDE0, 1'b1, 2'b10, "R7 hit1");
        fetch(24'h123457, 1'b1, 2'b00, "R7 near miss");
        fetch(24'h123456, 1'b0, 2'b00, "R7 no strobe");
        bus_write(AD_B1, 24'h123456);
        fetch(24'h123456, 1'b1, 2'b11, "R7 both");

        // R8 disabled comparator
        bus_write(AD_CTRL, 24'h000008);
        fetch(24'h123456, 1'b1, 2'b10, "R8 only brk1 enabled");
        bus_write(AD_CTRL, 24'h000000);
        fetch(24'h123456, 1'b1, 2'b00, "R8 both disabled");

        // R9 suppression in debug mode, R6 mode bit
        bus_write(AD_CTRL, 24'h00000C);
        core_dbg_mode = 1'b1;
        fetch(24'h123456, 1'b1, 2'b00, "R9 suppressed");
        bus_read(AD_CTRL, 32'h0000000D, "R6 mode reads 1");
        core_dbg_mode = 1'b0;
        bus_write(AD_CTRL, 24'h000001);
        bus_read(AD_CTRL, 32'h0, "R6 write ignored");

        // R3 latch, R4 clear behaviour
        pulse_req();
        bus_read(AD_CTRL, 32'h00000010, "R3 flag set");
        repeat (3) @(posedge clk);
        #1;
        bus_read(AD_CTRL, 32'h00000010, "R3 flag sticky");
        bus_write(AD_CTRL, 24'h000000);
        bus_read(AD_CTRL, 32'h00000010, "R4 write 0 no effect");
        bus_write(AD_CTRL, 24'h000010);
        bus_read(AD_CTRL, 32'h0, "R4 write 1 clears");

        // R5 set wins over clear
        pulse_req();
        ext_dbg_req = 1'b1;
        bus_write(AD_CTRL, 24'h000010);
        ext_dbg_req = 1'b0;
        bus_read(AD_CTRL, 32'h00000010, "R5 set wins");
        bus_write(AD_CTRL, 24'h000010);
        bus_read(AD_CTRL, 32'h0, "R5 cleared after");

        // R13 unmapped addresses
        bus_write(24'hFFFFA4, 24'hFFFFFF);
        bus_write(24'hFFFFB8, 24'hFFFFFF);
        bus_read(24'hFFFFA4, 32'h0, "R13 unmapped read a4");
        bus_read(24'hFFFFB8, 32'h0, "R13 unmapped read b8");
        bus_read(AD_CTRL, 32'h0, "R13 ctrl untouched");
        bus_read(AD_B0, 32'h00123456, "R13 brk0 untouched");
        bus_read(AD_B1, 32'h00123456, "R13 brk1 untouched");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL [scoreboard] actual=%0d expected=0 pending reads", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule